// File: doc/BRIEF.md
# Three-Phase Tetrahedron Step Sequencer

This block turns a three-phase multilevel reference, already split per phase into an integer level and a fractional remainder, into a four-state switching sequence for one switching period. The sequence starts with every phase on its lower level and ends with every phase one level higher. Each step raises exactly one phase, and the phase with the largest remainder goes first. The choice of step order is one of six, set by how the three remainders rank. Each state's dwell time is a difference of adjacent sorted remainders. As a result, every phase sits on its upper level for exactly its own remainder of the period, the same as if each phase were modulated on its own.

The period is `2**FRAC_W` clock cycles long, and remainders are counted in those cycles. The six input words are sampled on the clock edge that opens a period. They are held for the whole period, so the upstream controller can update them at any time. The outputs give the current level index of each phase, the number of steps taken so far in the period, and a strobe on the first cycle of each period. Mapping levels to gate signals is left to a downstream stage.

Top module: `tetra_seq`

## Requirements
- R1: While reset is asserted, all three level outputs are 0, the step number is 0 and the period strobe is low. The first period opens on the first clock edge after reset is released, and uses the inputs present at that edge.
- R2: A period lasts exactly `2**FRAC_W` cycles. The strobe is high only in its first cycle. In that cycle the step number is 0 and each level output equals the integer level latched for that phase.
- R3: Inputs are sampled only on the edge that opens a period. Changing any input during a period has no effect on any output until the next period opens.
- R4: A fraction input `f` means `f / 2**FRAC_W` of the period. In cycle `k` of a period (k = 0 at the strobe), a phase with latched level `L` and fraction `f` outputs `L+1` when `k >= 2**FRAC_W - f`, and outputs `L` otherwise. So it holds the upper level for exactly `f` cycles.
- R5: The step number always equals how many phases are on their upper level (0 to 3). Within a period it never decreases.
- R6: Phases rise in order of decreasing fraction, with ties resolved a before b before c. With the fractions sorted so that s1 >= s2 >= s3, steps 0, 1, 2 and 3 last `2**FRAC_W - s1`, `s1 - s2`, `s2 - s3` and `s3` cycles, which add up to the full period.
- R7: A step whose duration is zero is skipped outright and never shown for even one cycle. A phase whose fraction is 0 stays on its lower level for the whole period.
- R8: Within a period, each level output either stays the same or rises by exactly one, once, and never returns to the lower level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lvl_a_i | input | LVL_W | Integer level part, phase a |
| lvl_b_i | input | LVL_W | Integer level part, phase b |
| lvl_c_i | input | LVL_W | Integer level part, phase c |
| frac_a_i | input | FRAC_W | Fractional part, phase a, in cycles of the period |
| frac_b_i | input | FRAC_W | Fractional part, phase b |
| frac_c_i | input | FRAC_W | Fractional part, phase c |
| lvl_a_o | output | LVL_W | Current level index, phase a |
| lvl_b_o | output | LVL_W | Current level index, phase b |
| lvl_c_o | output | LVL_W | Current level index, phase c |
| state_o | output | 2 | Steps taken so far in this period |
| period_o | output | 1 | High in the first cycle of each period |

## Verification
The bench runs each of the six fraction orderings once. It also covers ties between two and between all three phases, all-zero fractions, maximal fractions and a fraction of 1. Ties and zeros are where a sequencer built on thresholds tends to go wrong: it may show a zero-length state for one stray cycle, or raise the wrong phase, or let a phase with a zero fraction rise at the wrap of the counter. Any of these shows up as a step duration or an upper-level dwell that does not match the sorted differences. Some periods get decoy inputs partway through. A design that samples its inputs continuously instead of at the boundary would change its levels in the middle of those periods.

// File: rtl/tetra_seq_pkg.sv
package tetra_seq_pkg;

    // Phase identifiers used for the step order.
    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } phase_e;

    localparam int NUM_PH = 3;

endpackage

// File: rtl/tetra_seq_rank.sv
// Orders the three phases by decreasing fraction; equal fractions keep a > b > c.
module tetra_seq_rank
    import tetra_seq_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic [NUM_PH-1:0][FRAC_W-1:0] frac_i,
    output phase_e [NUM_PH-1:0]           ord_o
);

    logic a_over_b, a_over_c, b_over_c;
    logic [1:0] rank_a, rank_b, rank_c;

    always_comb begin
        // "x over y" means x rises no later than y.
        a_over_b = frac_i[0] >= frac_i[1];
        a_over_c = frac_i[0] >= frac_i[2];
        b_over_c = frac_i[1] >= frac_i[2];

        rank_a = 2'(!a_over_b) + 2'(!a_over_c);
        rank_b = 2'(a_over_b)  + 2'(!b_over_c);
        rank_c = 2'(a_over_c)  + 2'(b_over_c);

        for (int k = 0; k < NUM_PH; k++) begin
            ord_o[k] = PH_A;
        end
        ord_o[rank_c] = PH_C;
        ord_o[rank_b] = PH_B;
        ord_o[rank_a] = PH_A;
    end

endmodule

// File: rtl/tetra_seq_thresh.sv
// Cumulative step thresholds: step k+1 begins at cycle FULL - frac of the k-th rising phase.
module tetra_seq_thresh
    import tetra_seq_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic [NUM_PH-1:0][FRAC_W-1:0] frac_i,
    input  phase_e [NUM_PH-1:0]           ord_i,
    output logic [NUM_PH-1:0][FRAC_W:0]   thr_o
);

    localparam logic [FRAC_W:0] FULL = (FRAC_W+1)'(1) << FRAC_W;

    always_comb begin
        for (int k = 0; k < NUM_PH; k++) begin
            thr_o[k] = FULL - {1'b0, frac_i[ord_i[k]]};
        end
    end

endmodule

// File: rtl/tetra_seq_dec.sv
// Decodes the period count against the held thresholds into levels and step number.
module tetra_seq_dec
    import tetra_seq_pkg::*;
#(
    parameter int LVL_W  = 4,
    parameter int FRAC_W = 8
) (
    input  logic [FRAC_W-1:0]             cnt_i,
    input  logic [NUM_PH-1:0][LVL_W-1:0]  base_i,
    input  logic [NUM_PH-1:0][FRAC_W:0]   thr_i,
    input  phase_e [NUM_PH-1:0]           ord_i,
    output logic [NUM_PH-1:0][LVL_W-1:0]  lvl_o,
    output logic [1:0]                    state_o
);

    logic [NUM_PH-1:0] crossed;

    always_comb begin
        for (int k = 0; k < NUM_PH; k++) begin
            crossed[k] = {1'b0, cnt_i} >= thr_i[k];
        end
        state_o = 2'(crossed[0]) + 2'(crossed[1]) + 2'(crossed[2]);
    end

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        logic [NUM_PH-1:0] hit;
        always_comb begin
            for (int k = 0; k < NUM_PH; k++) begin
                hit[k] = (ord_i[k] == phase_e'(p)) && crossed[k];
            end
            lvl_o[p] = base_i[p] + LVL_W'(|hit);
        end
    end

endmodule

// File: rtl/tetra_seq.sv
module tetra_seq
    import tetra_seq_pkg::*;
#(
    parameter int LVL_W  = 4,
    parameter int FRAC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [LVL_W-1:0]  lvl_a_i,
    input  logic [LVL_W-1:0]  lvl_b_i,
    input  logic [LVL_W-1:0]  lvl_c_i,
    input  logic [FRAC_W-1:0] frac_a_i,
    input  logic [FRAC_W-1:0] frac_b_i,
    input  logic [FRAC_W-1:0] frac_c_i,
    output logic [LVL_W-1:0]  lvl_a_o,
    output logic [LVL_W-1:0]  lvl_b_o,
    output logic [LVL_W-1:0]  lvl_c_o,
    output logic [1:0]        state_o,
    output logic              period_o
);

    localparam logic [FRAC_W-1:0] CNT_MAX = '1;
    localparam logic [FRAC_W:0]   FULL    = (FRAC_W+1)'(1) << FRAC_W;

    typedef struct packed {
        logic [FRAC_W-1:0]            cnt;
        logic [NUM_PH-1:0][LVL_W-1:0] base;
        logic [NUM_PH-1:0][FRAC_W:0]  thr;
        phase_e [NUM_PH-1:0]          ord;
    } seq_t;

    seq_t st_d, st_q;

    logic [NUM_PH-1:0][FRAC_W-1:0] frac_in;
    phase_e [NUM_PH-1:0]           ord_w;
    logic [NUM_PH-1:0][FRAC_W:0]   thr_w;
    logic [NUM_PH-1:0][LVL_W-1:0]  lvl_w;
    logic [1:0]                    state_w;

    assign frac_in = {frac_c_i, frac_b_i, frac_a_i};

    tetra_seq_rank #(.FRAC_W(FRAC_W)) u_rank (
        .frac_i (frac_in),
        .ord_o  (ord_w)
    );

    tetra_seq_thresh #(.FRAC_W(FRAC_W)) u_thresh (
        .frac_i (frac_in),
        .ord_i  (ord_w),
        .thr_o  (thr_w)
    );

    tetra_seq_dec #(.LVL_W(LVL_W), .FRAC_W(FRAC_W)) u_dec (
        .cnt_i   (st_q.cnt),
        .base_i  (st_q.base),
        .thr_i   (st_q.thr),
        .ord_i   (st_q.ord),
        .lvl_o   (lvl_w),
        .state_o (state_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (st_q.cnt == CNT_MAX) begin
            // period boundary: capture the whole new operating point at once
            st_d.base = {lvl_c_i, lvl_b_i, lvl_a_i};
            st_d.thr  = thr_w;
            st_d.ord  = ord_w;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cnt  <= CNT_MAX;
            st_q.base <= '0;
            for (int k = 0; k < NUM_PH; k++) begin
                st_q.thr[k] <= FULL;
                st_q.ord[k] <= phase_e'(k);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_a_o  = lvl_w[0];
    assign lvl_b_o  = lvl_w[1];
    assign lvl_c_o  = lvl_w[2];
    assign state_o  = state_w;
    assign period_o = (st_q.cnt == '0);

endmodule

// File: rtl/tetra_seq_chk.sv
module tetra_seq_chk #(
    parameter int LVL_W  = 4,
    parameter int FRAC_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [LVL_W-1:0]  lvl_a_o,
    input logic [LVL_W-1:0]  lvl_b_o,
    input logic [LVL_W-1:0]  lvl_c_o,
    input logic [1:0]        state_o,
    input logic              period_o
);

    localparam logic [FRAC_W:0] PER = (FRAC_W+1)'(1) << FRAC_W;

    logic [2:0][LVL_W-1:0] base_q;
    logic [2:0][LVL_W-1:0] base_eff;
    logic [2:0]            up;
    logic [FRAC_W:0]       pcnt_q;
    logic                  seen_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            base_q <= '0;
            pcnt_q <= '0;
            seen_q <= 1'b0;
        end else if (period_o) begin
            base_q <= {lvl_c_o, lvl_b_o, lvl_a_o};
            pcnt_q <= (FRAC_W+1)'(1);
            seen_q <= 1'b1;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    always_comb begin
        base_eff = period_o ? {lvl_c_o, lvl_b_o, lvl_a_o} : base_q;
        up[0] = lvl_a_o != base_eff[0];
        up[1] = lvl_b_o != base_eff[1];
        up[2] = lvl_c_o != base_eff[2];
    end

    a_r2_start_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_o |-> state_o == 2'd0);

    a_r2_period_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && pcnt_q == PER) |-> period_o);

    a_r2_no_early_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && period_o) |-> pcnt_q == PER);

    a_r5_state_counts_up_phases: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen_q |-> state_o == 2'($countones(up)));

    a_r5_state_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !period_o |-> state_o >= $past(state_o));

    a_r8_step_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!period_o && seen_q) |-> (lvl_a_o == base_q[0] || lvl_a_o == base_q[0] + 1'b1));

    a_r8_step_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!period_o && seen_q) |-> (lvl_b_o == base_q[1] || lvl_b_o == base_q[1] + 1'b1));

    a_r8_step_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!period_o && seen_q) |-> (lvl_c_o == base_q[2] || lvl_c_o == base_q[2] + 1'b1));

endmodule

bind tetra_seq tetra_seq_chk #(.LVL_W(LVL_W), .FRAC_W(FRAC_W)) u_tetra_seq_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_a_o  (lvl_a_o),
    .lvl_b_o  (lvl_b_o),
    .lvl_c_o  (lvl_c_o),
    .state_o  (state_o),
    .period_o (period_o)
);

// File: tb/test_tetra_seq.sv
module test_tetra_seq;

    localparam int LVL_W  = 4;
    localparam int FRAC_W = 8;
    localparam int PER    = 1 << FRAC_W;
    localparam int NV     = 13;
    localparam int LMASK  = (1 << LVL_W) - 1;

    typedef struct {
        int  lv[3];
        int  fr[3];
        bit  decoy;
    } vec_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LVL_W-1:0]  la, lb, lc;
    logic [FRAC_W-1:0] fa, fb, fc;
    logic [LVL_W-1:0]  oa, ob, oc;
    logic [1:0]        st;
    logic              per;

    int total = 0;
    int bad   = 0;
    int done  = 0;
    bit finished = 0;

    vec_t q[$];

    always #2 clk = ~clk;

    tetra_seq #(.LVL_W(LVL_W), .FRAC_W(FRAC_W)) i_tetra_seq (
        .clk_i(clk), .rst_ni(rst_n),
        .lvl_a_i(la), .lvl_b_i(lb), .lvl_c_i(lc),
        .frac_a_i(fa), .frac_b_i(fb), .frac_c_i(fc),
        .lvl_a_o(oa), .lvl_b_o(ob), .lvl_c_o(oc),
        .state_o(st), .period_o(per)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic vec_t mk(int a, int b, int c, int x, int y, int z, bit d);
        vec_t v;
        v.lv[0] = a; v.lv[1] = b; v.lv[2] = c;
        v.fr[0] = x; v.fr[1] = y; v.fr[2] = z;
        v.decoy = d;
        return v;
    endfunction

    function automatic vec_t vec(int i);
        case (i)
            0:  return mk(3, 3, 1, 200, 100, 50, 0);   // a>b>c
            1:  return mk(2, 0, 1, 180, 40, 120, 1);   // a>c>b
            2:  return mk(1, 1, 1, 30, 220, 90, 0);    // b>c>a
            3:  return mk(4, 2, 0, 90, 20, 160, 0);    // c>a>b
            4:  return mk(0, 5, 7, 10, 70, 250, 1);    // c>b>a
            5:  return mk(6, 6, 6, 120, 210, 5, 0);    // b>a>c
            6:  return mk(2, 2, 2, 128, 128, 128, 0);  // three-way tie
            7:  return mk(1, 2, 3, 77, 77, 0, 1);      // tie a=b, c zero
            8:  return mk(9, 8, 7, 0, 0, 0, 0);        // all zero
            9:  return mk(14, 13, 12, 255, 255, 255, 0);
            10: return mk(5, 5, 5, 40, 200, 200, 1);   // tie b=c
            11: return mk(3, 1, 2, 1, 0, 255, 0);
            default: return mk(7, 0, 3, 60, 150, 60, 0); // tie a=c
        endcase
    endfunction

    task automatic drive(vec_t v);
        la = LVL_W'(v.lv[0]); lb = LVL_W'(v.lv[1]); lc = LVL_W'(v.lv[2]);
        fa = FRAC_W'(v.fr[0]); fb = FRAC_W'(v.fr[1]); fc = FRAC_W'(v.fr[2]);
    endtask

    // Driver: pushes each vector as it is applied for the next boundary.
    initial begin
        vec_t v;
        v = vec(0);
        drive(v);
        q.push_back(v);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(oa == 0 && ob == 0 && oc == 0, "R1", "reset levels", {oc, ob, oa}, 0);
        chk(st == 0 && per == 0, "R1", "reset state/strobe", {st, per}, 0);
        rst_n = 1'b1;
        for (int i = 1; i < NV; i++) begin
            do @(negedge clk); while (!per);
            v = vec(i);
            if (v.decoy) begin
                drive(mk(11, 11, 11, 17, 17, 17, 0));
                repeat (100) @(negedge clk);
            end
            drive(v);
            q.push_back(v);
        end
        wait (done == NV);
        repeat (2) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Monitor: pops the expected operating point at each period start.
    vec_t cur;
    bit   have = 0;
    int   k = 0;
    int   prev_st = 0;
    int   upcnt[3];
    int   dur[4];

    task automatic finish_period(vec_t v);
        int s[3];
        int t;
        int e[4];
        int sum;
        for (int p = 0; p < 3; p++) begin
            // R4 / R7: dwell on the upper level equals the fraction
            chk(upcnt[p] == v.fr[p], v.fr[p] == 0 ? "R7" : "R4",
                "upper-level cycles", upcnt[p], v.fr[p]);
            s[p] = v.fr[p];
        end
        for (int i = 0; i < 2; i++)
            for (int j = 0; j < 2 - i; j++)
                if (s[j] < s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
        e[0] = PER - s[0]; e[1] = s[0] - s[1]; e[2] = s[1] - s[2]; e[3] = s[2];
        sum = 0;
        for (int i = 0; i < 4; i++) begin
            // R6 step durations; R7 zero-length steps never shown
            chk(dur[i] == e[i], e[i] == 0 ? "R7" : "R6", "step duration", dur[i], e[i]);
            sum += dur[i];
        end
        chk(sum == PER, "R2", "period length", sum, PER);
        done++;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (per) begin
                if (have) finish_period(cur);
                if (q.size() > 0) begin
                    cur = q.pop_front();
                    have = 1;
                    k = 0;
                    for (int p = 0; p < 3; p++) upcnt[p] = 0;
                    for (int i = 0; i < 4; i++) dur[i] = 0;
                end else begin
                    have = 0;
                end
            end else begin
                k++;
                if (have) begin
                    chk(k < PER, "R2", "missing strobe", k, PER - 1);
                    chk(int'(st) >= prev_st, "R5", "step number fell", st, prev_st);
                end
            end
            if (have) begin
                int up[3];
                int ea[3];
                int est;
                est = 0;
                for (int p = 0; p < 3; p++) begin
                    up[p] = (k + cur.fr[p] >= PER) ? 1 : 0;
                    ea[p] = (cur.lv[p] + up[p]) & LMASK;
                    est += up[p];
                    if (up[p] == 1) upcnt[p]++;
                end
                if (st <= 3) dur[st]++;
                chk(int'(oa) == ea[0] && int'(ob) == ea[1] && int'(oc) == ea[2] &&
                    int'(st) == est,
                    cur.decoy ? "R3" : (k == 0 ? "R2" : "R8"), "levels/step",
                    {oc, ob, oa, 2'b00, st}, (ea[2] << 14) | (ea[1] << 10) | (ea[0] << 6) | est);
                prev_st = st;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", done, NV);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule